// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer of a ten-bit successive-approximation converter with eight analog inputs. On a start request it records the channel number, the sampling path and the sampling length. It then keeps the input either behind the buffer amplifier or on the direct path for a set number of clocks. After that it runs a binary search, starting from the most significant bit, against an external comparator.

The trial code drives a segmented DAC. The upper seven bits pick one tap of an equal-value resistor string through a one-hot select of 128 lines. The lower three bits go out in binary to the switches of a charge-redistribution capacitor array. Each bit decision gets its own clock for zeroing the comparator. When the search ends, a single-clock completion pulse marks a new ten-bit result.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a synchronous reset, done, autoZero, bufEnable and bufBypass are 0, coarseTap and fineCode are all zero, result is 0 and muxSel is 0.
- R2: A start accepted in idle captures chanSel, bypassMode and sampleLen. muxSel shows the captured channel from then until done, whatever chanSel does meanwhile.
- R3: The sampling phase lasts sampleLen+1 clocks. bufEnable is high for all of them when bypassMode=0 was captured, and bufBypass is high for all of them when bypassMode=1. The two are never high together, and neither is high outside sampling.
- R4: Conversion takes exactly 20 clocks, with two per bit. autoZero is high on the first clock of each bit (10 single-clock pulses) and low on the second. done goes high sampleLen+21 clock edges after the edge that accepted start.
- R5: The search decides bits from bit 9 down to bit 0. A bit is kept when cmpHigh=1 (the input is at or above the DAC level) and cleared otherwise. For an ideal comparator with input v in 0..1023, the result equals v.
- R6: During conversion exactly one coarseTap line is high. Its index is bits 9:3 of the trial code, and fineCode carries bits 2:0 of the same code. Outside conversion both are all zero.
- R7: A start asserted while a conversion is in progress is ignored. It changes neither the timing, nor muxSel, nor the result, and it produces no extra done.
- R8: done is high for one clock only, and result is valid in that clock. result keeps its value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request a conversion (accepted only in idle) |
| chanSel | input | 3 | Analog channel to convert |
| bypassMode | input | 1 | 1 = sample with the buffer bypassed, 0 = through the buffer |
| sampleLen | input | 4 | Sampling length minus one, in clocks |
| cmpHigh | input | 1 | Comparator decision: 1 when the input is at or above the DAC level |
| muxSel | output | 3 | Analog multiplexer select (captured channel) |
| bufEnable | output | 1 | Buffer amplifier enable during buffered sampling |
| bufBypass | output | 1 | Buffer bypass switch during bypass sampling |
| coarseTap | output | 128 | One-hot resistor-string tap select |
| fineCode | output | 3 | Capacitor-array switch code |
| autoZero | output | 1 | Comparator zeroing strobe |
| result | output | 10 | Conversion result |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench uses the default parameters: ten result bits, a three-bit fine field (leaving a 128-tap coarse field) and a four-bit sampling length. With these values it can test both ends of the sampling length (0 and 15) against the exact latency. It can also test input levels at the extremes 0 and 1023 and the pair 511/512, where the coarse and fine fields both change. The ideal threshold model of the comparator turns every DAC level into the expected result, so each trial level also checks the one-hot decode against the binary fine field.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMP_BUF,
    ST_SAMP_BYP,
    ST_CONV
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // start accepted: latch the channel, clear the code
    logic converting;  // conversion in progress
    logic trialPhase;  // first clock of a bit
    logic decide;      // second clock of a bit: take the comparator
    logic lastBit;     // decide on bit 0
  } ctrlStrobe_t;

endpackage

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int LEN_BITS = 4,
  localparam int IDX_BITS = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic                bypassMode,
  input  logic [LEN_BITS-1:0] sampleLen,
  output ctrlStrobe_t         strobe,
  output logic [IDX_BITS-1:0] bitIdx,
  output logic                bufEnable,
  output logic                bufBypass,
  output logic                autoZero,
  output logic                done
);

  seqState_t           state;
  logic [LEN_BITS-1:0] sampCnt;
  logic                phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sampCnt <= '0;
      bitIdx  <= '0;
      phase   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= bypassMode ? ST_SAMP_BYP : ST_SAMP_BUF;
            sampCnt <= sampleLen;
          end
        end
        ST_SAMP_BUF, ST_SAMP_BYP: begin
          if (sampCnt == '0) begin
            state  <= ST_CONV;
            bitIdx <= IDX_BITS'(RES_BITS - 1);
            phase  <= 1'b0;
          end else begin
            sampCnt <= sampCnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bitIdx == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              bitIdx <= bitIdx - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture    = (state == ST_IDLE) && startReq;
    strobe.converting = (state == ST_CONV);
    strobe.trialPhase = strobe.converting && !phase;
    strobe.decide     = strobe.converting && phase;
    strobe.lastBit    = strobe.decide && (bitIdx == '0);
  end

  assign bufEnable = (state == ST_SAMP_BUF);
  assign bufBypass = (state == ST_SAMP_BYP);
  assign autoZero  = strobe.trialPhase;

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int FINE_BITS = 3,
  localparam int IDX_BITS    = $clog2(RES_BITS),
  localparam int COARSE_BITS = RES_BITS - FINE_BITS,
  localparam int TAP_COUNT   = 1 << COARSE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  input  logic [IDX_BITS-1:0]  bitIdx,
  input  logic [CHAN_BITS-1:0] chanSel,
  input  logic                 cmpHigh,
  output logic [CHAN_BITS-1:0] muxSel,
  output logic [TAP_COUNT-1:0] coarseTap,
  output logic [FINE_BITS-1:0] fineCode,
  output logic [RES_BITS-1:0]  result
);

  logic [RES_BITS-1:0] code;
  logic [RES_BITS-1:0] bitMask;
  logic [RES_BITS-1:0] trial;
  logic [RES_BITS-1:0] decided;

  assign bitMask = RES_BITS'(1) << bitIdx;
  assign trial   = code | bitMask;
  assign decided = cmpHigh ? trial : code;

  always_ff @(posedge clk) begin
    if (rst) begin
      muxSel <= '0;
      code   <= '0;
      result <= '0;
    end else begin
      if (strobe.capture) begin
        muxSel <= chanSel;
        code   <= '0;
      end
      if (strobe.decide) code <= decided;
      if (strobe.lastBit) result <= decided;
    end
  end

  for (genvar k = 0; k < TAP_COUNT; k++) begin : g_tap
    assign coarseTap[k] = strobe.converting &&
                          (trial[RES_BITS-1:FINE_BITS] == COARSE_BITS'(k));
  end

  assign fineCode = strobe.converting ? trial[FINE_BITS-1:0] : '0;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int FINE_BITS = 3,
  parameter int LEN_BITS  = 4,
  localparam int IDX_BITS    = $clog2(RES_BITS),
  localparam int COARSE_BITS = RES_BITS - FINE_BITS,
  localparam int TAP_COUNT   = 1 << COARSE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startReq,
  input  logic [CHAN_BITS-1:0] chanSel,
  input  logic                 bypassMode,
  input  logic [LEN_BITS-1:0]  sampleLen,
  input  logic                 cmpHigh,
  output logic [CHAN_BITS-1:0] muxSel,
  output logic                 bufEnable,
  output logic                 bufBypass,
  output logic [TAP_COUNT-1:0] coarseTap,
  output logic [FINE_BITS-1:0] fineCode,
  output logic                 autoZero,
  output logic [RES_BITS-1:0]  result,
  output logic                 done
);

  ctrlStrobe_t         strobe;
  logic [IDX_BITS-1:0] bitIdx;

  sar_ctrl_fsm #(
    .RES_BITS(RES_BITS),
    .LEN_BITS(LEN_BITS)
  ) ctrl_i (
    .clk(clk),
    .rst(rst),
    .startReq(startReq),
    .bypassMode(bypassMode),
    .sampleLen(sampleLen),
    .strobe(strobe),
    .bitIdx(bitIdx),
    .bufEnable(bufEnable),
    .bufBypass(bufBypass),
    .autoZero(autoZero),
    .done(done)
  );

  sar_datapath #(
    .RES_BITS(RES_BITS),
    .CHAN_BITS(CHAN_BITS),
    .FINE_BITS(FINE_BITS)
  ) dp_i (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .bitIdx(bitIdx),
    .chanSel(chanSel),
    .cmpHigh(cmpHigh),
    .muxSel(muxSel),
    .coarseTap(coarseTap),
    .fineCode(fineCode),
    .result(result)
  );

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_BITS  = 10,
  parameter int CHAN_BITS = 3,
  parameter int FINE_BITS = 3,
  parameter int TAP_COUNT = 128
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CHAN_BITS-1:0] muxSel,
  input logic                 bufEnable,
  input logic                 bufBypass,
  input logic [TAP_COUNT-1:0] coarseTap,
  input logic [FINE_BITS-1:0] fineCode,
  input logic                 autoZero,
  input logic [RES_BITS-1:0]  result,
  input logic                 done
);

  a_r3_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bufEnable && bufBypass));

  a_r3_no_sampling_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bufEnable && !bufBypass && !autoZero));

  a_r4_zero_then_decide: assert property (@(posedge clk) disable iff (rst)
    autoZero |=> (!autoZero && coarseTap != '0));

  a_r6_tap_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(coarseTap));

  a_r6_fine_idle_with_coarse: assert property (@(posedge clk) disable iff (rst)
    (coarseTap == '0) |-> (fineCode == '0 && !autoZero));

  a_r2_mux_held_in_conv: assert property (@(posedge clk) disable iff (rst)
    (coarseTap != '0) |-> $stable(muxSel));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_result_changes_only_at_done: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> done);

endmodule

bind sar_conv_ctrl sar_conv_chk #(
  .RES_BITS(RES_BITS),
  .CHAN_BITS(CHAN_BITS),
  .FINE_BITS(FINE_BITS),
  .TAP_COUNT(TAP_COUNT)
) chk_i (
  .clk(clk),
  .rst(rst),
  .muxSel(muxSel),
  .bufEnable(bufEnable),
  .bufBypass(bufBypass),
  .coarseTap(coarseTap),
  .fineCode(fineCode),
  .autoZero(autoZero),
  .result(result),
  .done(done)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         startReq;
  logic [2:0]   chanSel;
  logic         bypassMode;
  logic [3:0]   sampleLen;
  logic         cmpHigh;
  logic [2:0]   muxSel;
  logic         bufEnable;
  logic         bufBypass;
  logic [127:0] coarseTap;
  logic [2:0]   fineCode;
  logic         autoZero;
  logic [9:0]   result;
  logic         done;

  int vin;
  int tapIdx;
  int dacLevel;
  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  sar_conv_ctrl dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .chanSel(chanSel),
    .bypassMode(bypassMode), .sampleLen(sampleLen), .cmpHigh(cmpHigh),
    .muxSel(muxSel), .bufEnable(bufEnable), .bufBypass(bufBypass),
    .coarseTap(coarseTap), .fineCode(fineCode), .autoZero(autoZero),
    .result(result), .done(done)
  );

  // ideal threshold comparator on the segmented DAC level
  always_comb begin
    tapIdx = 0;
    for (int k = 0; k < 128; k++) if (coarseTap[k]) tapIdx = k;
    dacLevel = tapIdx * 8 + int'(fineCode);
    cmpHigh  = (vin >= dacLevel);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; startReq = 1'b0; chanSel = '0; bypassMode = 1'b0; sampleLen = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic checkReset();
    doReset();
    chk(done == 1'b0 && autoZero == 1'b0, "R1 done/autoZero", {done, autoZero}, 0);
    chk(bufEnable == 1'b0 && bufBypass == 1'b0, "R1 path switches", {bufEnable, bufBypass}, 0);
    chk(coarseTap == '0 && fineCode == '0, "R1 DAC drive", $countones(coarseTap) + fineCode, 0);
    chk(result == '0 && muxSel == '0, "R1 result/mux", result + muxSel, 0);
  endtask

  // one conversion with full per-cycle bookkeeping; pokeAt>=0 re-asserts start mid-run
  task automatic runConv(input int chan, input bit byp, input int len, input int v, input int pokeAt);
    int cycles = 0, enCnt = 0, bypCnt = 0, azCnt = 0, tapCnt = 0;
    int badMux = 0, badTap = 0, extraDone = 0;
    vin = v;
    @(negedge clk);
    chanSel = 3'(chan); bypassMode = byp; sampleLen = 4'(len); startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0; chanSel = 3'(~chan); bypassMode = ~byp; sampleLen = 4'(~len);
    while (!done && cycles < 100) begin
      if (bufEnable) enCnt++;
      if (bufBypass) bypCnt++;
      if (autoZero) azCnt++;
      if (coarseTap != '0) tapCnt++;
      if (muxSel != 3'(chan)) badMux++;
      if ($countones(coarseTap) > 1 || (coarseTap == '0 && fineCode != '0)) badTap++;
      startReq = (cycles == pokeAt);
      if (startReq) chanSel = 3'(chan + 3);
      @(posedge clk);
      cycles++;
      @(negedge clk);
      startReq = 1'b0;
    end
    chk(cycles == len + 21, "R4 latency start to done", cycles, len + 21);
    chk(azCnt == 10, "R4 autoZero pulses", azCnt, 10);
    chk(tapCnt == 20, "R6 clocks with a tap driven", tapCnt, 20);
    chk(badTap == 0, "R6 one-hot tap / fine idle", badTap, 0);
    chk(enCnt == (byp ? 0 : len + 1), "R3 buffered sampling clocks", enCnt, byp ? 0 : len + 1);
    chk(bypCnt == (byp ? len + 1 : 0), "R3 bypass sampling clocks", bypCnt, byp ? len + 1 : 0);
    chk(badMux == 0 && muxSel == 3'(chan), "R2 channel held", muxSel, chan);
    chk(result == 10'(v), "R5 result of search", result, v);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single clock", done, 0);
    if (pokeAt >= 0) begin
      for (int i = 0; i < 40; i++) begin
        if (done || bufEnable || bufBypass) extraDone++;
        @(negedge clk);
      end
      chk(extraDone == 0, "R7 busy start ignored", extraDone, 0);
    end
  endtask

  task automatic holdTest();
    int held;
    held = int'(result);
    vin = 1023 - held;
    repeat (12) @(negedge clk);
    chk(int'(result) == held, "R8 result held after done", result, held);
  endtask

  initial begin
    vin = 0;
    checkReset();
    runConv(0, 1'b0, 0, 0, -1);
    runConv(7, 1'b0, 15, 1023, -1);
    runConv(3, 1'b1, 2, 512, -1);
    runConv(4, 1'b1, 0, 511, -1);
    runConv(5, 1'b0, 5, 341, -1);
    runConv(2, 1'b1, 15, 700, -1);
    runConv(1, 1'b0, 3, 7, -1);
    holdTest();
    runConv(6, 1'b0, 4, 600, 12);
    runConv(1, 1'b1, 1, 8, 2);
    holdTest();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule